// File: doc/BRIEF.md
# Double Bus Fault Detector

This block watches the exception sequencer of a processor core and decides when an error has become unrecoverable. An error counts only if it arrives while the core is still handling an earlier error or a reset. A protection window opens when the sequencer starts handling a bus error, address error or reset exception. The window closes when that handling completes. A bus error or address error seen while the window is open is a double fault. The block then latches a halt that only reset can release.

While halted, the block holds its status line high without a break. At other times the same line carries short indications of one to three clock periods, requested by the sequencer. Bus arbitration keeps working during the halt: the request input is passed to the grant output one cycle later, whether the block is halted or not. The asynchronous active-low reset is synchronised inside the block, so its release takes effect after a short delay.

Top module: `dbf_detector`

## Requirements
- R1: After reset `halt`, `status` and `bus_grant` are all 0.
- R2: When `exc_start` is sampled with `exc_type` 0 (reset), 1 (bus error) or 2 (address error), the window is open from the next cycle on. A qualifying error sampled while the window is open sets `halt` and `status` to 1 on that same clock edge. A qualifying error sampled in the same cycle as the opening strobe is not a fault.
- R3: When `exc_done` is sampled, the window closes from the next cycle on. After that, errors do not set `halt`, and neither do errors while no window was ever opened.
- R4: `exc_start` with any `exc_type` from 3 to 7 does not open the window, so a later error does not set `halt`.
- R5: `bus_err` sampled together with `retry` is not a qualifying error. `addr_err` is a qualifying error whatever the value of `retry`.
- R6: Once set, `halt` stays 1 until reset, whatever is applied to the other inputs.
- R7: While `halt` is 1, `status` is 1 on every cycle, and indication requests do not lower it.
- R8: `ind_go` sampled with `ind_len` n (1 to 3), while no indication is running, makes `status` 1 for exactly n cycles. It starts on the edge that samples the request. `ind_len` 0 gives no pulse. A request made while an indication is running is ignored.
- R9: `bus_grant` equals the value `bus_req` had at the previous clock edge, including while `halt` is 1.
- R10: When `exc_start` (with a window type) and `exc_done` are sampled in the same cycle, the window is open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_err | input | 1 | Bus error on the current cycle |
| addr_err | input | 1 | Address error on the current cycle |
| retry | input | 1 | Current bus cycle is being retried |
| exc_start | input | 1 | Sequencer begins exception handling |
| exc_done | input | 1 | Sequencer finishes exception handling |
| exc_type | input | 3 | Kind of exception started: 0 reset, 1 bus error, 2 address error, 3-7 others |
| ind_go | input | 1 | Request a short status indication |
| ind_len | input | 2 | Indication length in cycles (0 gives none) |
| bus_req | input | 1 | Bus arbitration request |
| halt | output | 1 | Permanent halt after a double fault |
| status | output | 1 | Status line: held high when halted, else indication pulses |
| bus_grant | output | 1 | Bus arbitration grant |

## Verification
On every cycle, assertions check the following: halt never drops once set, and it never rises without a fault from the window logic. Status is high whenever halt is high. A retried bus error alone never causes a halt. The grant tracks the request through the halt. The window never stays open past a completion strobe, and a non-window exception never opens it. An indication loads its length and then only counts down. Only the bench scenarios can show the rest: which sequences of start, completion and error strobes end in a halt, the exact pulse widths for each length, that requests made during a pulse are ignored, and that reset alone clears a halt.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int EXC_W = 3;
  localparam int LEN_W = 2;

  typedef logic [EXC_W-1:0] exc_t;

  localparam exc_t EXC_RESET = exc_t'(0);
  localparam exc_t EXC_BERR  = exc_t'(1);
  localparam exc_t EXC_AERR  = exc_t'(2);

  function automatic logic opens_window(exc_t t);
    return (t == EXC_RESET) || (t == EXC_BERR) || (t == EXC_AERR);
  endfunction
endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dbf_window.sv
module dbf_window
  import dbf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_start,
  input  logic exc_done,
  input  exc_t exc_type,
  input  logic bus_err,
  input  logic addr_err,
  input  logic retry,
  output logic fault
);
  logic win_q, win_d;
  logic opener, err_valid;

  always_comb begin
    err_valid = (bus_err & ~retry) | addr_err;
    opener    = exc_start & opens_window(exc_type);
    win_d     = win_q;
    if (exc_done) win_d = 1'b0;
    if (opener)   win_d = 1'b1;
    fault     = win_q & err_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  // R3: completion without a new qualifying start closes the window
  p_win_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_done && !(exc_start && opens_window(exc_type))) |=> !win_q);

  // R4: a non-window exception never opens a closed window
  p_win_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_q && !(exc_start && opens_window(exc_type))) |=> !win_q);
endmodule

// File: rtl/dbf_halt_latch.sv
module dbf_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  output logic halt_d,
  output logic halt_q
);
  always_comb begin
    halt_d = halt_q | fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  // R6: halt is permanent until reset
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> halt_q);

  // R2: halt rises only on a fault from the window logic
  p_halt_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_q && !fault) |=> !halt_q);
endmodule

// File: rtl/dbf_pulse.sv
module dbf_pulse #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ind_go,
  input  logic [LEN_W-1:0] ind_len,
  output logic             active_d
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             idle;

  always_comb begin
    idle  = (cnt_q == '0);
    cnt_d = cnt_q;
    if (!idle)       cnt_d = cnt_q - 1'b1;
    else if (ind_go) cnt_d = ind_len;
    active_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: an accepted request loads its length
  p_pulse_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ind_go) |=> (cnt_q == $past(ind_len)));

  // R8: a running indication only counts down, requests ignored
  p_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/dbf_detector.sv
module dbf_detector
  import dbf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IND_W       = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_err,
  input  logic             addr_err,
  input  logic             retry,
  input  logic             exc_start,
  input  logic             exc_done,
  input  logic [EXC_W-1:0] exc_type,
  input  logic             ind_go,
  input  logic [IND_W-1:0] ind_len,
  input  logic             bus_req,
  output logic             halt,
  output logic             status,
  output logic             bus_grant
);
  logic rst_s;
  logic fault, halt_d, halt_q, pulse_d;
  logic status_q, status_d, grant_q, grant_d;

  dbf_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  dbf_window u_win (
    .clk(clk), .rst_n(rst_s), .exc_start(exc_start), .exc_done(exc_done),
    .exc_type(exc_type), .bus_err(bus_err), .addr_err(addr_err),
    .retry(retry), .fault(fault)
  );

  dbf_halt_latch u_halt (
    .clk(clk), .rst_n(rst_s), .fault(fault), .halt_d(halt_d), .halt_q(halt_q)
  );

  dbf_pulse #(.LEN_W(IND_W)) u_pulse (
    .clk(clk), .rst_n(rst_s), .ind_go(ind_go), .ind_len(ind_len),
    .active_d(pulse_d)
  );

  always_comb begin
    status_d = halt_d | pulse_d;
    grant_d  = bus_req;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      status_q <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      grant_q  <= grant_d;
    end
  end

  assign halt      = halt_q;
  assign status    = status_q;
  assign bus_grant = grant_q;

  // R7: status is held while halted
  p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    halt |-> status);

  // R9: arbitration keeps working, halted or not
  p_grant_follow_r9: assert property (@(posedge clk) disable iff (!rst_s)
    bus_req |=> bus_grant);

  // R5: a retried bus error alone never starts a halt
  p_retry_mask_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_err && retry && !addr_err && !halt) |=> !halt);
endmodule

// File: tb/dbf_detector_test.sv
`timescale 1ns/1ps
module dbf_detector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_err = 1'b0, addr_err = 1'b0, retry = 1'b0;
  logic       exc_start = 1'b0, exc_done = 1'b0;
  logic [2:0] exc_type = 3'd0;
  logic       ind_go = 1'b0;
  logic [1:0] ind_len = 2'd0;
  logic       bus_req = 1'b0;
  logic       halt, status, bus_grant;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dbf_detector uut (
    .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .addr_err(addr_err),
    .retry(retry), .exc_start(exc_start), .exc_done(exc_done),
    .exc_type(exc_type), .ind_go(ind_go), .ind_len(ind_len),
    .bus_req(bus_req), .halt(halt), .status(status), .bus_grant(bus_grant)
  );

  // fields: [14:11] req, [10] reset first, [9] bus_err, [8] addr_err,
  // [7] retry, [6] start, [5] done, [4:2] type, [1] exp halt, [0] exp status
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {4'd1,  11'b1_000_00_000_00}, // R1 idle after reset
    {4'd2,  11'b0_000_10_001_00}, // R2 open with bus error type
    {4'd2,  11'b0_100_00_000_11}, // R2 error inside window
    {4'd5,  11'b1_000_10_000_00}, // R5 open with reset type
    {4'd5,  11'b0_101_00_000_00}, // R5 retried bus error ignored
    {4'd5,  11'b0_011_00_000_11}, // R5 address error not masked
    {4'd3,  11'b1_000_10_010_00}, // R3 open with address error type
    {4'd3,  11'b0_000_01_000_00}, // R3 close
    {4'd3,  11'b0_100_00_000_00}, // R3 error after close
    {4'd4,  11'b1_000_10_101_00}, // R4 other type
    {4'd4,  11'b0_010_00_000_00}, // R4 error, no window
    {4'd10, 11'b1_000_11_001_00}, // R10 start and done together
    {4'd10, 11'b0_100_00_000_11}, // R10 window open
    {4'd3,  11'b1_100_00_000_00}, // R3 error with no window ever
    {4'd2,  11'b1_100_10_001_00}, // R2 error with opening strobe
    {4'd2,  11'b0_100_00_000_11}  // R2 next error faults
  };

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    bus_err = 0; addr_err = 0; retry = 0; exc_start = 0; exc_done = 0;
    exc_type = 0; ind_go = 0; ind_len = 0; bus_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic make_fault();
    do_reset();
    exc_start = 1; exc_type = 3'd1;
    @(negedge clk);
    exc_start = 0; bus_err = 1;
    @(negedge clk);
    bus_err = 0;
  endtask

  task automatic pulse_count(input logic [1:0] len, input bit second_go,
                             output int n);
    n = 0;
    @(negedge clk);
    ind_go = 1; ind_len = len;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!(second_go && i == 0)) begin ind_go = 0; ind_len = 0; end
      if (status) n++;
    end
    ind_go = 0; ind_len = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    chk("R1", "halt", halt, 1'b0);
    chk("R1", "status", status, 1'b0);
    chk("R1", "bus_grant", bus_grant, 1'b0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[v][14:11]);
      if (VEC[v][10]) do_reset();
      else @(negedge clk);
      bus_err = VEC[v][9]; addr_err = VEC[v][8]; retry = VEC[v][7];
      exc_start = VEC[v][6]; exc_done = VEC[v][5]; exc_type = VEC[v][4:2];
      @(posedge clk);
      #1;
      chk(tag, $sformatf("vec%0d halt", v), halt, VEC[v][1]);
      chk(tag, $sformatf("vec%0d status", v), status, VEC[v][0]);
      @(negedge clk);
      clear_inputs();
    end

    // R6: halt survives completion, new starts and errors
    make_fault();
    exc_done = 1; exc_start = 1; exc_type = 3'd5; addr_err = 1;
    repeat (20) @(negedge clk);
    clear_inputs();
    @(negedge clk);
    chk("R6", "halt sticky", halt, 1'b1);

    // R7: status stays high while halted despite indication requests
    n = 0;
    ind_go = 1; ind_len = 2'd1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (status) n++;
    end
    ind_go = 0;
    chk("R7", "status held 10 cycles", n == 10, 1'b1);

    // R9: grant follows request while halted
    @(negedge clk); bus_req = 1;
    @(posedge clk); #1;
    chk("R9", "grant high while halted", bus_grant, 1'b1);
    @(negedge clk); bus_req = 0;
    @(posedge clk); #1;
    chk("R9", "grant low while halted", bus_grant, 1'b0);

    // R1: reset clears a halt
    do_reset();
    chk("R1", "halt cleared", halt, 1'b0);
    chk("R1", "status cleared", status, 1'b0);

    // R8: indication lengths
    for (int len = 0; len < 4; len++) begin
      pulse_count(2'(len), 1'b0, n);
      if (n != len) begin
        checks++; failures++;
        $display("FAIL R8 pulse len%0d actual=%0d expected=%0d", len, n, len);
      end else checks++;
    end

    // R8: request during a pulse is ignored
    pulse_count(2'd3, 1'b1, n);
    if (n != 3) begin
      checks++; failures++;
      $display("FAIL R8 busy request actual=%0d expected=3", n);
    end else checks++;

    // R9: grant outside halt
    @(negedge clk); bus_req = 1;
    @(posedge clk); #1;
    chk("R9", "grant idle", bus_grant, 1'b1);
    @(negedge clk); bus_req = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule